// File: doc/BRIEF.md
# Scan-Chain Byte Bridge

This block is a byte-wide serial link between a host that drives a test-access-port scan chain and on-chip logic. The host reaches it through the capture, shift and update strobes of a selected data register, with one serial input and one serial output. On the chip side, bytes from the host come out on a valid/ready stream, and bytes for the host go in on a second valid/ready stream. Each direction is buffered in its own 8-entry queue.

Every scan is one frame of 72 bits: a header byte followed by eight byte slots. Bits leave and enter LSB first, header first. At capture the block loads the frame it sends with the number of bytes it offers (up to 8) and the number of free receive entries. At update it takes in what the host sent, limited to the space it advertised, and retires the bytes it offered. The strobes are single-cycle enables in the block's own clock domain. Capture, shift and update never occur in the same cycle, and an update follows the capture of the same scan. The queue depth must be a power of two no larger than 15, and the slot count must be no larger than 15.

Back-pressure on the chip side follows the usual rules. A byte moves only in a cycle where both valid and ready are high. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value. `tx_ready` is low whenever the transmit queue is full, and a byte offered then is not taken.

Top module: `jtag_byte_bridge`

## Requirements
- R1: After reset, both queues are empty: `tx_level` is 0, `rx_free` is 8, `rx_valid` is 0, `tx_ready` is 1 and `tdo` is 0.
- R2: A frame is 72 bits long with bit 0 first. Right after capture, `tdo` shows frame bit 0. Each shift cycle brings the next frame bit to `tdo` and takes `tdi` in as the next incoming frame bit.
- R3: The outgoing header byte (frame bits 7:0) carries min(`tx_level`, 8) in bits 7:4 and the free receive entry count in bits 3:0, both as they were at capture.
- R4: Outgoing byte slot k (frame bits 8k+15:8k+8) holds the k-th oldest transmit byte for each k below the offered count. Every other slot is zero.
- R5: At update, the block queues the first min(c, f) incoming slots for the receive stream, in slot order. Here c is bits 7:4 of the incoming header (values above 8 count as 8) and f is the free count advertised at that scan's capture. Outside update, `rx_free` never decreases.
- R6: The offered transmit bytes leave the transmit queue only at update, all in that cycle. `tx_level` stays unchanged through capture and shifting. Bytes that were not offered stay queued, in order.
- R7: An update strobe with no capture since the previous update moves no byte in either direction.
- R8: `rx_valid` is high exactly when the receive queue holds a byte, and `rx_data` is the oldest such byte. While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` stay stable.
- R9: `tx_ready` is high exactly when the transmit queue holds fewer than 8 bytes. A byte is queued only when `tx_valid` and `tx_ready` are both high.
- R10: `tx_level` is the number of queued transmit bytes and `rx_free` is 8 minus the number of queued receive bytes. Both are updated on the cycle after each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_capture | input | 1 | Capture strobe of the selected data register |
| tap_shift | input | 1 | Shift strobe, one bit per cycle |
| tap_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host |
| tx_data | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit queue can take a byte |
| rx_data | output | 8 | Oldest byte received from the host |
| rx_valid | output | 1 | `rx_data` holds a byte |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| tx_level | output | 4 | Bytes waiting to go to the host |
| rx_free | output | 4 | Free receive entries |

## Verification
The main function is tried with random mixes of transmit queue fill, incoming header count and receive space, including header counts from 9 to 15. These cases separate the limit taken from the host count from the limit taken from the advertised space. Directed frames cover an empty transmit queue, which checks that all slots are zeroed, and a full one, which checks that all eight slots are filled oldest first. They also cover a full transmit queue with a stalled producer, which shows whether a refused byte is queued anyway. A lone update with no capture shows whether stale offer counts are reused. Holding `rx_ready` low shows whether the receive stream stays stable under back-pressure.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_NIB = 4;

  function automatic int umin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/jsb_fifo.sv
module jsb_fifo
  import jsb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int WR_PORTS = 1,
  parameter int RD_PORTS = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int WW = $clog2(WR_PORTS + 1),
  localparam int RW = $clog2(RD_PORTS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [WW-1:0]                    push_n,
  input  logic [WR_PORTS-1:0][BYTE_W-1:0]  push_data,
  input  logic [RW-1:0]                    pop_n,
  output logic [CW-1:0]                    level,
  output logic [RD_PORTS-1:0][BYTE_W-1:0]  peek
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      for (int i = 0; i < WR_PORTS; i++) begin
        if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_data[i];
      end
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + CW'(push_n) - CW'(pop_n);
    end
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_peek
    assign peek[g] = mem[rd_ptr + AW'(g)];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) + int'(push_n) - int'(pop_n) <= DEPTH); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(level)); // R6
endmodule

// File: rtl/jsb_frame.sv
module jsb_frame
  import jsb_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int FW = BYTE_W * (SLOTS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic                          shift,
  input  logic                          tdi,
  input  logic [FW-1:0]                 load,
  output logic                          tdo,
  output logic [HDR_NIB-1:0]            host_cnt,
  output logic [SLOTS-1:0][BYTE_W-1:0]  host_bytes
);
  logic [FW-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= load;
    else if (shift)   sr <= {tdi, sr[FW-1:1]};
  end

  assign tdo      = sr[0];
  assign host_cnt = sr[BYTE_W-1:BYTE_W-HDR_NIB];
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign host_bytes[g] = sr[BYTE_W*(g+1) +: BYTE_W];
  end

  AST_TDO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> tdo == $past(load[0])); // R2
  AST_TDO_TAKES_TDI: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> sr[FW-1] == $past(tdi)); // R2
endmodule

// File: rtl/jtag_byte_bridge.sv
module jtag_byte_bridge
  import jsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SLOTS = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(SLOTS + 1),
  localparam int FW = BYTE_W * (SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tap_capture,
  input  logic          tap_shift,
  input  logic          tap_update,
  input  logic          tdi,
  output logic          tdo,
  input  logic [7:0]    tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_free
);
  logic [CW-1:0]                  tx_lvl, rx_lvl;
  logic [SLOTS-1:0][BYTE_W-1:0]   tx_peek;
  logic [0:0][BYTE_W-1:0]         rx_peek;
  logic [SW-1:0]                  tx_avail, arm_tx, host_lim, rx_acc;
  logic [SW-1:0]                  rx_push_n, tx_pop_n;
  logic [CW-1:0]                  arm_free;
  logic [FW-1:0]                  load_frame;
  logic [HDR_NIB-1:0]             host_cnt;
  logic [SLOTS-1:0][BYTE_W-1:0]   host_bytes;

  // offer and space seen at capture
  assign tx_avail = SW'(umin(int'(tx_lvl), SLOTS));
  assign rx_free  = CW'(DEPTH) - rx_lvl;
  assign tx_level = tx_lvl;

  always_comb begin
    load_frame = '0;
    load_frame[BYTE_W-1:BYTE_W-HDR_NIB] = HDR_NIB'(tx_avail);
    load_frame[HDR_NIB-1:0]             = HDR_NIB'(rx_free);
    for (int i = 0; i < SLOTS; i++) begin
      if (i < int'(tx_avail)) load_frame[BYTE_W*(i+1) +: BYTE_W] = tx_peek[i];
    end
  end

  // counts armed by capture, consumed by the matching update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_tx   <= '0;
      arm_free <= '0;
    end else if (tap_capture) begin
      arm_tx   <= tx_avail;
      arm_free <= rx_free;
    end else if (tap_update) begin
      arm_tx   <= '0;
      arm_free <= '0;
    end
  end

  assign host_lim  = SW'(umin(int'(host_cnt), SLOTS));
  assign rx_acc    = SW'(umin(int'(host_lim), int'(arm_free)));
  assign rx_push_n = tap_update ? rx_acc : '0;
  assign tx_pop_n  = tap_update ? arm_tx : '0;

  assign tx_ready = int'(tx_lvl) < DEPTH;
  assign rx_valid = rx_lvl != '0;
  assign rx_data  = rx_peek[0];

  jsb_frame #(.SLOTS(SLOTS)) u_frame (
    .clk(clk), .rst_n(rst_n), .capture(tap_capture), .shift(tap_shift),
    .tdi(tdi), .load(load_frame), .tdo(tdo),
    .host_cnt(host_cnt), .host_bytes(host_bytes)
  );

  jsb_fifo #(.DEPTH(DEPTH), .WR_PORTS(SLOTS), .RD_PORTS(1)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_data(host_bytes),
    .pop_n(rx_valid && rx_ready), .level(rx_lvl), .peek(rx_peek)
  );

  jsb_fifo #(.DEPTH(DEPTH), .WR_PORTS(1), .RD_PORTS(SLOTS)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .push_n(tx_valid && tx_ready), .push_data(tx_data),
    .pop_n(tx_pop_n), .level(tx_lvl), .peek(tx_peek)
  );

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R8
  AST_TX_POP_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_update |=> tx_level >= $past(tx_level)); // R6
  AST_RX_PUSH_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_update |=> rx_free >= $past(rx_free)); // R5
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_free) <= DEPTH)); // R10
endmodule

// File: tb/jtag_byte_bridge_tb.sv
`timescale 1ns/1ps
module jtag_byte_bridge_tb;
  logic clk = 0, rst_n = 0;
  logic tap_capture = 0, tap_shift = 0, tap_update = 0, tdi = 0;
  logic tdo;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 0;
  logic [3:0] tx_level, rx_free;

  int n_cmp = 0, n_bad = 0;
  byte unsigned txq[$];
  byte unsigned rxq[$];

  always #4 clk = ~clk;

  jtag_byte_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .tap_capture(tap_capture), .tap_shift(tap_shift),
    .tap_update(tap_update), .tdi(tdi), .tdo(tdo), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_level(tx_level), .rx_free(rx_free)
  );

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [71:0] exp_out();
    logic [71:0] f = '0;
    int n = mn(txq.size(), 8);
    f[7:4] = 4'(n);
    f[3:0] = 4'(8 - rxq.size());
    for (int i = 0; i < n; i++) f[8*(i+1) +: 8] = txq[i];
    return f;
  endfunction

  task automatic check_status(input string tag);
    chk(tx_level == 4'(txq.size()), {tag, " R10 tx_level"}, 72'(tx_level), 72'(txq.size()));
    chk(rx_free == 4'(8 - rxq.size()), {tag, " R10 rx_free"}, 72'(rx_free), 72'(8 - rxq.size()));
    chk(tx_ready == (txq.size() < 8), {tag, " R9 tx_ready"}, 72'(tx_ready), 72'(txq.size() < 8));
    chk(rx_valid == (rxq.size() > 0), {tag, " R8 rx_valid"}, 72'(rx_valid), 72'(rxq.size() > 0));
  endtask

  // full scan with model update and frame check
  task automatic scan(input logic [71:0] fin);
    logic [71:0] fout;
    logic [71:0] fexp;
    int n_off, free_cap, acc;
    fexp = exp_out();
    n_off = mn(txq.size(), 8);
    free_cap = 8 - rxq.size();
    @(negedge clk) tap_capture = 1;
    @(negedge clk) tap_capture = 0;
    chk(tx_level == 4'(txq.size()), "R6 no pop at capture", 72'(tx_level), 72'(txq.size()));
    for (int k = 0; k < 72; k++) begin
      fout[k] = tdo;
      tdi = fin[k];
      tap_shift = 1;
      @(negedge clk);
    end
    tap_shift = 0;
    tdi = 0;
    chk(tx_level == 4'(txq.size()), "R6 no pop while shifting", 72'(tx_level), 72'(txq.size()));
    chk(fout[7:0] == fexp[7:0], "R3 header", 72'(fout[7:0]), 72'(fexp[7:0]));
    chk(fout[71:8] == fexp[71:8], "R4 R2 data slots", fout, fexp);
    tap_update = 1;
    @(negedge clk) tap_update = 0;
    for (int i = 0; i < n_off; i++) void'(txq.pop_front());
    acc = mn(mn(int'(fin[7:4]), 8), free_cap);
    for (int i = 0; i < acc; i++) rxq.push_back(fin[8*(i+1) +: 8]);
    check_status("R5 R6 after update");
  endtask

  task automatic push_tx(input byte unsigned b);
    bit acc;
    @(negedge clk);
    acc = tx_ready;
    chk(tx_ready == (txq.size() < 8), "R9 tx_ready before push", 72'(tx_ready), 72'(txq.size() < 8));
    tx_valid = 1;
    tx_data = b;
    @(negedge clk) tx_valid = 0;
    if (acc) txq.push_back(b);
  endtask

  task automatic pop_rx();
    @(negedge clk);
    chk(rx_valid == (rxq.size() > 0), "R8 rx_valid", 72'(rx_valid), 72'(rxq.size() > 0));
    if (rxq.size() > 0)
      chk(rx_data == rxq[0], "R8 R5 rx order", 72'(rx_data), 72'(rxq[0]));
    rx_ready = 1;
    @(negedge clk) rx_ready = 0;
    if (rxq.size() > 0) void'(rxq.pop_front());
  endtask

  function automatic logic [71:0] host_frame(input int cnt);
    logic [71:0] f = '0;
    f[7:4] = 4'(cnt);
    f[3:0] = 4'($urandom_range(0, 15));
    for (int i = 0; i < 8; i++) f[8*(i+1) +: 8] = 8'($urandom_range(0, 255));
    return f;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin : main
    logic [71:0] f;
    logic [7:0] held;
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_level == 0, "R1 tx_level", 72'(tx_level), 0);
    chk(rx_free == 8, "R1 rx_free", 72'(rx_free), 8);
    chk(rx_valid == 0, "R1 rx_valid", 72'(rx_valid), 0);
    chk(tx_ready == 1, "R1 tx_ready", 72'(tx_ready), 1);
    chk(tdo == 0, "R1 tdo", 72'(tdo), 0);

    // empty transmit queue, host sends three bytes
    f = '0;
    f[7:4] = 3;
    f[15:8] = 8'hAA; f[23:16] = 8'hBB; f[31:24] = 8'hCC; f[39:32] = 8'hDD;
    scan(f);

    // fill transmit queue beyond its depth: R9
    for (int i = 0; i < 10; i++) push_tx(8'(8'h40 + i));
    chk(tx_ready == 0, "R9 full queue refuses", 72'(tx_ready), 0);
    check_status("R9 full");
    // host count 15 with 5 free: R5 clamp to space
    scan(host_frame(15));

    // R8 hold under back-pressure
    @(negedge clk);
    held = rx_data;
    repeat (4) begin
      @(negedge clk);
      chk(rx_valid && rx_data == held, "R8 hold", 72'(rx_data), 72'(held));
    end
    while (rxq.size() > 0) pop_rx();

    // R7 lone update moves nothing
    push_tx(8'h77);
    @(negedge clk) tap_update = 1;
    @(negedge clk) tap_update = 0;
    check_status("R7 lone update");
    f = '0;
    f[7:4] = 2;
    scan(f);
    chk(rxq.size() == 2, "R5 two accepted", 72'(rxq.size()), 2);

    // random mix
    for (int it = 0; it < 150; it++) begin
      int np = $urandom_range(0, 10);
      for (int j = 0; j < np; j++) push_tx(8'($urandom_range(0, 255)));
      scan(host_frame($urandom_range(0, 15)));
      begin
        int nd = $urandom_range(0, 9);
        for (int j = 0; j < nd; j++) pop_rx();
      end
      check_status("random");
    end
    while (rxq.size() > 0) pop_rx();
    scan('0);
    check_status("drained");
    report();
    $finish;
  end
endmodule